// File: doc/BRIEF.md
# Load/Store Alignment and Beat Sequencer

This unit sits between a load/store pipeline and a 32-bit data memory. It takes one access request at a time. A request carries an access kind, a byte address, a word count for multi-word transfers, and two mode bits. The unit turns the request into one or more memory beats. Each beat carries a memory address with the low bits forced as the mode requires, and a flag that marks the access as architecturally unpredictable. While the access is active, the unit also rotates the word read from memory so that it lands where the pipeline expects it.

With both mode bits low, the unit runs in legacy mode. It does not trap misaligned addresses. It clears the low address bits the access size calls for, rotates data returned by misaligned word loads, and flags the kind/offset pairs that have no defined result. In strict mode the unit applies the same address forcing, does no rotation, and flags every misalignment. In unaligned mode the raw address passes through untouched. The mode is captured when a request is accepted. Two-word, doubleword and multi-word transfers are issued one word per cycle under a valid/ready handshake, with each beat at the previous address plus four. Only the little-endian model is handled.

Top module: `ldst_align_unit`

## Requirements
- R1: Byte kinds (plain byte, code 0, and sync byte, code 1) issue one beat at the raw address with the unpredictable flag low and no rotation, in every mode.
- R2: In legacy mode, halfword kinds (plain, code 2, and sync, code 3) issue one beat at the address with bit 0 cleared. The flag equals address bit 0 and data is not rotated.
- R3: In legacy mode, a word load (code 4) issues one beat at the address with bits [1:0] cleared. The flag is low, and the load data equals the memory word rotated right by 8 times address bits [1:0].
- R4: In legacy mode, a word store (code 5) and a sync word (code 6) issue one beat at the address with bits [1:0] cleared and no rotation. The flag is low for the store; for the sync word it is set when address bits [1:0] are nonzero.
- R5: A sync doubleword (code 7) issues two beats starting at the address with bits [2:0] cleared. Outside unaligned mode, the flag is set when any of address bits [2:0] is nonzero.
- R6: In legacy mode, a two-word access (code 8) issues two beats from the address with bits [1:0] cleared, flagged when any of address bits [2:0] is nonzero. A multi-word access (code 9) issues req_cnt+1 beats from the same cleared address, and its flag is low.
- R7: In a burst, every beat after the first is at the previous beat's address plus 4. All beats carry the same flag and the same rotation.
- R8: After reset, req_ready is high and beat_valid is low. A request is accepted when req_valid and req_ready are both high. Its first beat is valid in the next cycle, and request inputs are ignored from then on. A beat holds while beat_ready is low. beat_last marks the final beat, and req_ready is low from acceptance until the cycle after the final beat's handshake.
- R9: With mode_unal high (whatever mode_chk is), every kind starts at the raw address with no rotation and the flag low. The beat count is the same as in legacy mode.
- R10: With mode_chk high and mode_unal low, addresses are forced as in legacy mode and data is not rotated. The flag is address bit 0 for halfwords and any of bits [2:0] for the sync doubleword. For the remaining word kinds (codes 4, 5, 6, 8 and 9) it is any of bits [1:0]. Byte kinds stay unflagged.
- R11: Kind codes 10 to 15 are handled exactly as a plain byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_kind | input | 4 | Access kind code (see R1 to R6, R11) |
| req_addr | input | 32 | Byte address of the access |
| req_cnt | input | CNT_W (4) | Multi-word count minus one |
| mode_chk | input | 1 | Strict alignment mode |
| mode_unal | input | 1 | Unaligned pass-through mode, overrides mode_chk |
| beat_valid | output | 1 | Memory beat present |
| beat_ready | input | 1 | Memory accepts the current beat |
| beat_addr | output | 32 | Address of the current beat |
| beat_unpred | output | 1 | Access is architecturally unpredictable |
| beat_last | output | 1 | Current beat is the final one of the request |
| mem_rdata | input | 32 | Word read from memory for the current beat |
| ld_data | output | 32 | Load data after rotation |

## Verification
The assertions assume that mem_rdata belongs to the beat on the output in the same cycle. They also assume that beat_ready may drop at any time, and that request fields only matter in the cycle a request is accepted. The bench follows these rules. It raises req_valid only when it expects the unit to be idle. After acceptance it replaces the request fields with unrelated values, so a beat that still followed the inputs would show up. On a fixed schedule it holds beat_ready low for a cycle, and it drives a fresh memory word on every beat. The sweep covers every kind code, every value of address bits [2:0] and all four mode combinations. Multi-word counts vary from 1 to 16 words.

// File: rtl/ldst_align_pkg.sv
package ldst_align_pkg;

  typedef enum logic [3:0] {
    KIND_BYTE   = 4'd0,
    KIND_BSYNC  = 4'd1,
    KIND_HALF   = 4'd2,
    KIND_HSYNC  = 4'd3,
    KIND_WLOAD  = 4'd4,
    KIND_WSTORE = 4'd5,
    KIND_WSYNC  = 4'd6,
    KIND_DSYNC  = 4'd7,
    KIND_PAIR   = 4'd8,
    KIND_MULTI  = 4'd9
  } acc_kind_e;

  localparam int unsigned KIND_W = 4;

endpackage

// File: rtl/ldst_align_decode.sv
module ldst_align_decode
  import ldst_align_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned OFS_W  = 2
) (
  input  logic [KIND_W-1:0] kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              chk_i,
  input  logic              unal_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              unpred_o,
  output logic [OFS_W-1:0]  rot_o,
  output logic [CNT_W-1:0]  last_idx_o
);

  localparam int unsigned DW_W = OFS_W + 1;

  logic              mis_half;
  logic              mis_word;
  logic              mis_dword;
  logic              legacy;
  logic [ADDR_W-1:0] addr_half;
  logic [ADDR_W-1:0] addr_word;
  logic [ADDR_W-1:0] addr_dword;

  assign mis_half   = addr_i[0];
  assign mis_word   = |addr_i[OFS_W-1:0];
  assign mis_dword  = |addr_i[DW_W-1:0];
  assign legacy     = ~chk_i;
  assign addr_half  = {addr_i[ADDR_W-1:1], 1'b0};
  assign addr_word  = {addr_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign addr_dword = {addr_i[ADDR_W-1:DW_W], {DW_W{1'b0}}};

  always_comb begin
    base_o     = addr_i;
    unpred_o   = 1'b0;
    rot_o      = '0;
    last_idx_o = '0;
    case (kind_i)
      KIND_HALF, KIND_HSYNC: begin
        base_o   = addr_half;
        unpred_o = mis_half;
      end
      KIND_WLOAD: begin
        base_o   = addr_word;
        unpred_o = chk_i & mis_word;
        rot_o    = legacy ? addr_i[OFS_W-1:0] : '0;
      end
      KIND_WSTORE: begin
        base_o   = addr_word;
        unpred_o = chk_i & mis_word;
      end
      KIND_WSYNC: begin
        base_o   = addr_word;
        unpred_o = mis_word;
      end
      KIND_DSYNC: begin
        base_o     = addr_dword;
        unpred_o   = mis_dword;
        last_idx_o = CNT_W'(1);
      end
      KIND_PAIR: begin
        base_o     = addr_word;
        unpred_o   = chk_i ? mis_word : mis_dword;
        last_idx_o = CNT_W'(1);
      end
      KIND_MULTI: begin
        base_o     = addr_word;
        unpred_o   = chk_i & mis_word;
        last_idx_o = cnt_i;
      end
      default: begin
        base_o   = addr_i;
        unpred_o = 1'b0;
      end
    endcase
    if (unal_i) begin
      base_o   = addr_i;
      unpred_o = 1'b0;
      rot_o    = '0;
    end
  end

endmodule

// File: rtl/ldst_align_seq.sv
module ldst_align_seq #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              unpred_i,
  input  logic [OFS_W-1:0]  rot_i,
  input  logic [CNT_W-1:0]  last_idx_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic              beat_unpred_o,
  output logic [OFS_W-1:0]  beat_rot_o,
  output logic              beat_last_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << OFS_W;

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              unpred_q;
  logic [OFS_W-1:0]  rot_q;
  logic              accept;
  logic              fire;
  logic              done;
  logic              step_en;

  assign accept  = req_valid_i & ~busy_q;
  assign fire    = busy_q & beat_ready_i;
  assign done    = fire & (left_q == '0);
  assign step_en = accept | (fire & ~done);

  always_comb begin
    busy_d = busy_q;
    if (accept) begin
      busy_d = 1'b1;
    end else if (done) begin
      busy_d = 1'b0;
    end
    addr_d = accept ? base_i : addr_q + STEP;
    left_d = accept ? last_idx_i : left_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (step_en) begin
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unpred_q <= 1'b0;
      rot_q    <= '0;
    end else if (accept) begin
      unpred_q <= unpred_i;
      rot_q    <= rot_i;
    end
  end

  assign req_ready_o   = ~busy_q;
  assign beat_valid_o  = busy_q;
  assign beat_addr_o   = addr_q;
  assign beat_unpred_o = unpred_q;
  assign beat_rot_o    = rot_q;
  assign beat_last_o   = busy_q & (left_q == '0);

  assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && req_ready_o |=> beat_valid_o && !req_ready_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_addr_o) && $stable(beat_last_o));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && beat_ready_i && beat_last_o |=> !beat_valid_o && req_ready_o);

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o && beat_ready_i && !beat_last_o |=>
      beat_valid_o && (beat_addr_o == $past(beat_addr_o) + STEP) && $stable(beat_unpred_o) && $stable(beat_rot_o));

endmodule

// File: rtl/ldst_align_rotate.sv
module ldst_align_rotate #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFS_W  = 2
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFS_W-1:0]  rot_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int unsigned LANES = DATA_W / 8;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [OFS_W-1:0] src;
    assign src = OFS_W'(k) + rot_i;
    assign data_o[8*k +: 8] = data_i[8*int'(src) +: 8];
  end

endmodule

// File: rtl/ldst_align_unit.sv
module ldst_align_unit
  import ldst_align_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_cnt,
  input  logic              mode_chk,
  input  logic              mode_unal,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_unpred,
  output logic              beat_last,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] ld_data
);

  localparam int unsigned OFS_W = $clog2(DATA_W / 8);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] dec_base;
  logic              dec_unpred;
  logic [OFS_W-1:0]  dec_rot;
  logic [CNT_W-1:0]  dec_last_idx;
  logic [OFS_W-1:0]  beat_rot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  ldst_align_decode #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .OFS_W  (OFS_W)
  ) u_decode (
    .kind_i     (req_kind),
    .addr_i     (req_addr),
    .cnt_i      (req_cnt),
    .chk_i      (mode_chk),
    .unal_i     (mode_unal),
    .base_o     (dec_base),
    .unpred_o   (dec_unpred),
    .rot_o      (dec_rot),
    .last_idx_o (dec_last_idx)
  );

  ldst_align_seq #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .OFS_W  (OFS_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .req_valid_i   (req_valid),
    .req_ready_o   (req_ready),
    .base_i        (dec_base),
    .unpred_i      (dec_unpred),
    .rot_i         (dec_rot),
    .last_idx_i    (dec_last_idx),
    .beat_valid_o  (beat_valid),
    .beat_ready_i  (beat_ready),
    .beat_addr_o   (beat_addr),
    .beat_unpred_o (beat_unpred),
    .beat_rot_o    (beat_rot),
    .beat_last_o   (beat_last)
  );

  ldst_align_rotate #(
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
  ) u_rotate (
    .data_i (mem_rdata),
    .rot_i  (beat_rot),
    .data_o (ld_data)
  );

  assert_byte_raw_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid && req_ready && (req_kind inside {4'd0, 4'd1, [4'd10:4'd15]}) |=>
      beat_addr == $past(req_addr) && !beat_unpred && beat_last);

  assert_dword_align_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid && req_ready && (req_kind == KIND_DSYNC) && !mode_unal |=>
      beat_addr[OFS_W:0] == '0 && !beat_last);

  assert_rot_single_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    beat_valid && (beat_rot != '0) |-> beat_last);

  assert_unal_raw_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid && req_ready && mode_unal |=> beat_addr == $past(req_addr) && !beat_unpred && beat_rot == '0);

endmodule

// File: tb/ldst_align_unit_tb.sv
module ldst_align_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [3:0]  req_kind;
  logic [31:0] req_addr;
  logic [3:0]  req_cnt;
  logic        mode_chk;
  logic        mode_unal;
  logic        beat_valid;
  logic        beat_ready;
  logic [31:0] beat_addr;
  logic        beat_unpred;
  logic        beat_last;
  logic [31:0] mem_rdata;
  logic [31:0] ld_data;

  int total = 0;
  int bad   = 0;

  ldst_align_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_cnt(req_cnt),
    .mode_chk(mode_chk), .mode_unal(mode_unal),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_addr(beat_addr), .beat_unpred(beat_unpred), .beat_last(beat_last),
    .mem_rdata(mem_rdata), .ld_data(ld_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [31:0] rotr(input logic [31:0] d, input int r);
    if (r == 0) return d;
    return (d >> (8 * r)) | (d << (32 - 8 * r));
  endfunction

  function automatic string tag_of(input int kind, input bit chk, input bit unal);
    if (unal) return "R9";
    if (chk) return "R10";
    case (kind)
      0, 1: return "R1";
      2, 3: return "R2";
      4: return "R3";
      5, 6: return "R4";
      7: return "R5";
      8, 9: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic model(input int kind, input logic [31:0] a, input int cnt, input bit chk, input bit unal,
                       output logic [31:0] base, output bit unp, output int rot, output int nb);
    bit m1, m2, m3;
    m1 = a[0];
    m2 = (a % 4) != 0;
    m3 = (a % 8) != 0;
    base = a; unp = 0; rot = 0; nb = 1;
    case (kind)
      2, 3: begin base = a - (a % 2); unp = m1; end
      4: begin base = a - (a % 4); unp = chk & m2; rot = chk ? 0 : int'(a % 4); end
      5: begin base = a - (a % 4); unp = chk & m2; end
      6: begin base = a - (a % 4); unp = m2; end
      7: begin base = a - (a % 8); unp = m3; nb = 2; end
      8: begin base = a - (a % 4); unp = chk ? m2 : m3; nb = 2; end
      9: begin base = a - (a % 4); unp = chk & m2; nb = cnt + 1; end
      default: ;
    endcase
    if (unal) begin base = a; unp = 0; rot = 0; end
  endtask

  task automatic run_req(input int kind, input logic [31:0] a, input int cnt, input bit chk, input bit unal, input int tag);
    logic [31:0] eb;
    bit eu;
    int er;
    int nb;
    logic [31:0] md;
    logic [31:0] hold;
    string t;
    model(kind, a, cnt, chk, unal, eb, eu, er, nb);
    t = tag_of(kind, chk, unal);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 4'(kind); req_addr = a; req_cnt = 4'(cnt);
    mode_chk = chk; mode_unal = unal; beat_ready = 1'b0;
    #1;
    check(req_ready == 1'b1 && beat_valid == 1'b0, "R8", {30'd0, req_ready, beat_valid}, 32'd2);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_kind = 4'(kind + 5); req_cnt = 4'(cnt + 7);
    mode_chk = ~chk; mode_unal = ~unal;
    for (int b = 0; b < nb; b++) begin
      if (((tag + b) % 3) == 1) begin
        beat_ready = 1'b0;
        #1 hold = beat_addr;
        @(posedge clk);
        @(negedge clk);
        check(beat_valid == 1'b1 && beat_addr == hold, "R8", beat_addr, hold);
      end
      md = (32'(tag) * 32'h0101_0107) ^ (32'(b) * 32'h3C5A_9617) ^ 32'hA5C3_1E69;
      mem_rdata = md;
      beat_ready = 1'b1;
      #1;
      check(beat_valid == 1'b1 && req_ready == 1'b0, "R8", {30'd0, beat_valid, req_ready}, 32'd2);
      check(beat_addr == eb + 32'(4 * b), (b == 0) ? t : "R7", beat_addr, eb + 32'(4 * b));
      check(beat_unpred == eu, (b == 0) ? t : "R7", {31'd0, beat_unpred}, {31'd0, eu});
      check(beat_last == (b == nb - 1), "R8", {31'd0, beat_last}, {31'd0, b == nb - 1});
      check(ld_data == rotr(md, er), (er != 0) ? "R3" : t, ld_data, rotr(md, er));
      @(posedge clk);
      @(negedge clk);
    end
    beat_ready = 1'b0;
    #1;
    check(beat_valid == 1'b0 && req_ready == 1'b1, "R8", {30'd0, beat_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    int tag;
    logic [31:0] seed;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_addr = '0; req_cnt = '0;
    mode_chk = 1'b0; mode_unal = 1'b0; beat_ready = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(req_ready == 1'b1 && beat_valid == 1'b0, "R8", {30'd0, req_ready, beat_valid}, 32'd2);
    tag = 0;
    seed = 32'h1357_9BDF;
    for (int mode = 0; mode < 4; mode++) begin
      for (int kind = 0; kind < 16; kind++) begin
        for (int lo = 0; lo < 8; lo++) begin
          seed = seed * 32'd1664525 + 32'd1013904223;
          run_req(kind, (seed & 32'hFFFF_FFF8) | 32'(lo), (lo * 5 + kind + mode) % 16,
                  mode[0], mode[1], tag);
          tag++;
        end
      end
    end
    run_req(9, 32'hFFFF_FFF0, 15, 1'b0, 1'b1, tag);
    run_req(4, 32'h0000_0003, 0, 1'b0, 1'b0, tag + 1);
    run_req(7, 32'h0000_0007, 0, 1'b0, 1'b0, tag + 2);
    finish_run();
  end

endmodule